// File: doc/BRIEF.md
# Eight-Pixel Group Collector with Chained Bus Token

This block sits beside a cluster of eight pixels (two wide, four tall) in a pixel-matrix column. Each pixel raises a request when it holds a finished 28-bit hit measurement. The group takes at most one request per cycle, visiting the pixels in rotating order. It tags the measurement with the 3-bit pixel number to form a 31-bit record and stores the record in a two-entry local queue.

Up to 64 such groups share one column bus toward the end-of-column logic. A token ripples from the top of the column through every group. An idle group lets the token straight through in the same cycle. A group with a queued record keeps the token, drives the bus and waits for the bus-ready handshake. After each accepted word the group steps aside until the token has travelled to the end of the chain unclaimed. That event is fed back to every group as `round_end`. The result is that each group sends at most one word per round, and a busy group near the top cannot lock out the groups below it. Because an idle group drives zeros, the bus words of all groups can be OR-combined.

Top module: `sp_collector`

## Requirements
- R1: After reset the queue is empty, no pixel is acknowledged, `bus_valid` is 0 and `tok_out` follows `tok_in`; the rotation starts at pixel 0.
- R2: At most one bit of `pix_ack` is high in a cycle, and only for a requesting pixel. The stored record is {pixel number in bits 30:28, pixel measurement in bits 27:0}.
- R3: Among the requesting pixels, the acknowledged one is the first at or after (last acknowledged + 1) mod 8, counting upward with wrap-around; before any grant that start point is 0.
- R4: The queue holds two records and sends them in arrival order. While it holds two, no pixel is acknowledged, and a waiting request stays pending until it is taken, so no hit is lost.
- R5: A group with an empty queue or one that is stepping aside drives `tok_out` equal to `tok_in` in the same cycle.
- R6: A group with a queued record, `tok_in` high and not stepping aside raises `bus_valid`, holds `tok_out` low and drives its oldest record; at most one group of a chain drives the bus.
- R7: A record leaves the queue only in a cycle with `bus_valid` and `bus_ready` both high. While `bus_ready` is low and the token keeps arriving, the same word stays on the bus.
- R8: After an accepted word the group does not drive the bus in the next cycle. It steps aside until it sees `round_end` high in a cycle with no transfer of its own.
- R9: `bus_data` is all zeros whenever `bus_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Active-low reset |
| pix_req | input | 8 | One request per pixel, held until acknowledged |
| pix_data | input | 224 | Eight 28-bit measurements, pixel p at bits p*28 upward |
| pix_ack | output | 8 | One-cycle acknowledge to the pixel taken this cycle |
| tok_in | input | 1 | Token from the group above |
| tok_out | output | 1 | Token to the group below |
| round_end | input | 1 | High when the token left the chain end unclaimed |
| bus_ready | input | 1 | End-of-column accepts the word this cycle |
| bus_valid | output | 1 | This group drives a word |
| bus_data | output | 31 | Record word, zero when not valid |

## Verification
The bench chains four groups with the default eight pixels, 28-bit measurements and two-entry queue. `round_end` is fed from the last token output. With only four groups, a high hit rate keeps the queues full most of the time, so acknowledge blocking, simultaneous push and pop, and many rotation start points all occur often. Random bus stalls and a gapped top-of-column token exercise word holding, stepping aside and round restart in every order. Each pixel word carries its group, pixel and a sequence number, so a lost, duplicated or reordered record is detected when it appears on the bus.

// File: rtl/sp_pkg.sv
package sp_pkg;

  localparam int SP_PIXELS     = 8;
  localparam int SP_PIX_DW     = 28;
  localparam int SP_FIFO_DEPTH = 2;

  // Next start point of a rotation over n positions.
  function automatic int rr_next(int idx, int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // Occupancy after one cycle of optional write and read.
  function automatic int occ_next(int occ, bit put, bit take);
    return occ + int'(put) - int'(take);
  endfunction

  // Wrap-around increment of a storage slot number.
  function automatic int slot_next(int slot, int depth);
    return (slot + 1 >= depth) ? 0 : slot + 1;
  endfunction

endpackage

// File: rtl/sp_rr_arbiter.sv
module sp_rr_arbiter #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          en,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_vld
);

  logic [IW-1:0] ptr_q;
  logic [N-1:0]  upper;

  function automatic logic [IW-1:0] first_set(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  // requests at or above the rotation start point
  for (genvar i = 0; i < N; i++) begin : g_upper
    assign upper[i] = req[i] && (i >= int'(ptr_q));
  end

  assign gnt_idx = (|upper) ? first_set(upper) : first_set(req);
  assign gnt_vld = en && (|req);
  assign gnt     = gnt_vld ? (N'(1) << gnt_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (gnt_vld) begin
      ptr_q <= IW'(sp_pkg::rr_next(int'(gnt_idx), N));
    end
  end

  // R2: one grant at most, never to an idle pixel
  a_r2_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)) else $error("grant not one-hot");
  a_r2_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0) else $error("grant to idle pixel");

endmodule

// File: rtl/sp_fifo.sv
module sp_fifo #(
  parameter int W     = 31,
  parameter int DEPTH = 2,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign dout  = mem[rd_q];

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= PW'(sp_pkg::slot_next(int'(wr_q), DEPTH));
      if (pop)  rd_q <= PW'(sp_pkg::slot_next(int'(rd_q), DEPTH));
      cnt_q <= CW'(sp_pkg::occ_next(int'(cnt_q), push, pop));
    end
  end

  // R4: nothing is written into a full queue
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full) else $error("write into full queue");
  // R7: nothing is read from an empty queue
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty) else $error("read from empty queue");

endmodule

// File: rtl/sp_token_ctl.sv
module sp_token_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic tok_in,
  input  logic has_data,
  input  logic bus_ready,
  input  logic round_end,
  output logic own,
  output logic tok_out,
  output logic accept
);

  logic yld_q;

  assign own     = tok_in && has_data && !yld_q;
  assign tok_out = tok_in && !own;
  assign accept  = own && bus_ready;

  // a transfer starts a stand-aside period; a round end closes it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         yld_q <= 1'b0;
    else if (accept)    yld_q <= 1'b1;
    else if (round_end) yld_q <= 1'b0;
  end

  // R8: no second word right after an accepted one
  a_r8_yield_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !own) else $error("drove bus right after transfer");
  // R7: a stalled word stays while the token keeps arriving
  a_r7_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (own && !bus_ready) |=> (own || !tok_in)) else $error("dropped stalled word");

endmodule

// File: rtl/sp_collector.sv
module sp_collector #(
  parameter int NPIX       = sp_pkg::SP_PIXELS,
  parameter int PIX_DW     = sp_pkg::SP_PIX_DW,
  parameter int FIFO_DEPTH = sp_pkg::SP_FIFO_DEPTH,
  localparam int IDX_W = $clog2(NPIX),
  localparam int REC_W = PIX_DW + IDX_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPIX-1:0]        pix_req,
  input  logic [NPIX*PIX_DW-1:0] pix_data,
  output logic [NPIX-1:0]        pix_ack,
  input  logic                   tok_in,
  output logic                   tok_out,
  input  logic                   round_end,
  input  logic                   bus_ready,
  output logic                   bus_valid,
  output logic [REC_W-1:0]       bus_data
);

  logic [IDX_W-1:0]  gnt_idx;
  logic              gnt_vld;
  logic [PIX_DW-1:0] data_sel;
  logic [REC_W-1:0]  rec_in, rec_head;
  logic              q_full, q_empty;
  logic              own, accept;

  function automatic logic [REC_W-1:0] make_record(
    input logic [IDX_W-1:0] idx, input logic [PIX_DW-1:0] meas);
    return {idx, meas};
  endfunction

  sp_rr_arbiter #(.N(NPIX)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (pix_req),
    .en      (!q_full),
    .gnt     (pix_ack),
    .gnt_idx (gnt_idx),
    .gnt_vld (gnt_vld)
  );

  assign data_sel = pix_data[int'(gnt_idx)*PIX_DW +: PIX_DW];
  assign rec_in   = make_record(gnt_idx, data_sel);

  sp_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (gnt_vld),
    .din   (rec_in),
    .pop   (accept),
    .dout  (rec_head),
    .full  (q_full),
    .empty (q_empty)
  );

  sp_token_ctl u_tok (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_in    (tok_in),
    .has_data  (!q_empty),
    .bus_ready (bus_ready),
    .round_end (round_end),
    .own       (own),
    .tok_out   (tok_out),
    .accept    (accept)
  );

  assign bus_valid = own;
  assign bus_data  = own ? rec_head : '0;

  // R4: a full queue blocks every acknowledge
  a_r4_full_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> (pix_ack == '0)) else $error("ack while full");
  // R5: an empty group is transparent to the token
  a_r5_empty_passes: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty |-> (tok_out == tok_in && !bus_valid)) else $error("empty group held token");
  // R6: a driving group has received the token
  a_r6_valid_needs_token: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (tok_in && !tok_out)) else $error("drove bus without token");
  // R7: stalled word is unchanged next cycle while token stays
  a_r7_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (!tok_in || (bus_valid && $stable(bus_data))))
    else $error("stalled word changed");
  // R9: the bus is quiet when not valid
  a_r9_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (bus_data == '0)) else $error("bus not quiet");

endmodule

// File: tb/sp_collector_tb.sv
module sp_collector_tb;

  localparam int NG = 4;
  localparam int NP = 8;
  localparam int DW = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NP-1:0]    req   [NG];
  logic [NP*DW-1:0] pd    [NG];
  logic [NP-1:0]    ack   [NG];
  logic             vld   [NG];
  logic [30:0]      bd    [NG];
  logic [NG:0]      tok;
  logic             head_tok = 1'b1;
  logic             ready = 1'b0;

  assign tok[0] = head_tok;

  sp_collector u_dut (
    .clk(clk), .rst_n(rst_n), .pix_req(req[0]), .pix_data(pd[0]), .pix_ack(ack[0]),
    .tok_in(tok[0]), .tok_out(tok[1]), .round_end(tok[NG]), .bus_ready(ready),
    .bus_valid(vld[0]), .bus_data(bd[0]));

  for (genvar g = 1; g < NG; g++) begin : g_more
    sp_collector u_grp (
      .clk(clk), .rst_n(rst_n), .pix_req(req[g]), .pix_data(pd[g]), .pix_ack(ack[g]),
      .tok_in(tok[g]), .tok_out(tok[g+1]), .round_end(tok[NG]), .bus_ready(ready),
      .bus_valid(vld[g]), .bus_data(bd[g]));
  end

  int nchk = 0;
  int nfail = 0;

  // bench model
  int          cnt [NG];
  bit          yld [NG];
  int          ptr [NG];
  logic [30:0] q   [NG][$];
  bit          pend [NG][NP];
  logic [27:0] pval [NG][NP];
  bit          hold_prev [NG];
  logic [30:0] hold_dat  [NG];
  bit          xfer_prev [NG];
  int          seq = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input int hit_pct, input int rdy_pct, input int tok_pct);
    for (int g = 0; g < NG; g++) begin
      for (int p = 0; p < NP; p++) begin
        if (!pend[g][p] && ($urandom % 100) < hit_pct) begin
          pend[g][p] = 1'b1;
          pval[g][p] = {2'(g), 3'(p), 23'(seq)};
          seq++;
        end
        req[g][p] = pend[g][p];
        pd[g][p*DW +: DW] = pend[g][p] ? pval[g][p] : '0;
      end
    end
    ready    = ($urandom % 100) < rdy_pct;
    head_tok = ($urandom % 100) < tok_pct;
  endtask

  task automatic step(input int hit_pct, input int rdy_pct, input int tok_pct);
    bit t;
    bit eo [NG];
    int nv;
    @(negedge clk);
    drive(hit_pct, rdy_pct, tok_pct);
    #2;
    t = head_tok;
    nv = 0;
    for (int g = 0; g < NG; g++) begin
      eo[g] = t && cnt[g] > 0 && !yld[g];
      chk(vld[g] == eo[g], $sformatf("R6 owner g%0d", g), vld[g], eo[g]);
      if (g == 0) chk(tok[1] == (t && !eo[g]), "R5 token out", tok[1], t && !eo[g]);
      if (!vld[g]) chk(bd[g] == '0, "R9 quiet bus", bd[g], 0);
      if (eo[g] && vld[g]) chk(bd[g] == q[g][0], $sformatf("R2/R4 record g%0d", g), bd[g], q[g][0]);
      if (hold_prev[g] && eo[g]) chk(bd[g] == hold_dat[g], "R7 stalled word", bd[g], hold_dat[g]);
      if (xfer_prev[g]) chk(!vld[g], "R8 stand aside", vld[g], 0);
      if (vld[g]) nv++;
      t = t && !eo[g];
    end
    chk(tok[NG] == t, "R5 chain end", tok[NG], t);
    chk(nv <= 1, "R6 collision", nv, 1);
    // acknowledge check and model update
    for (int g = 0; g < NG; g++) begin
      logic [NP-1:0] ea;
      int pick;
      bit xf;
      ea = '0;
      pick = -1;
      if (cnt[g] < 2) begin
        for (int k = 0; k < NP; k++) begin
          int i;
          i = (ptr[g] + k) % NP;
          if (pick < 0 && pend[g][i]) pick = i;
        end
        if (pick >= 0) ea[pick] = 1'b1;
      end
      chk(ack[g] == ea, cnt[g] == 2 ? "R4 full blocks ack" : "R3 rotation pick", ack[g], ea);
      xf = eo[g] && ready;
      if (xf) void'(q[g].pop_front());
      if (pick >= 0) begin
        q[g].push_back({3'(pick), pval[g][pick]});
        pend[g][pick] = 1'b0;
        ptr[g] = (pick + 1) % NP;
      end
      cnt[g] = cnt[g] + (pick >= 0 ? 1 : 0) - (xf ? 1 : 0);
      if (xf) yld[g] = 1'b1;
      else if (tok[NG]) yld[g] = 1'b0;
      hold_prev[g] = eo[g] && !ready;
      hold_dat[g]  = bd[g];
      xfer_prev[g] = xf;
    end
  endtask

  function automatic bit all_done();
    for (int g = 0; g < NG; g++) begin
      if (cnt[g] != 0) return 1'b0;
      for (int p = 0; p < NP; p++) if (pend[g][p]) return 1'b0;
    end
    return 1'b1;
  endfunction

  initial begin
    for (int g = 0; g < NG; g++) begin
      req[g] = '0; pd[g] = '0;
      cnt[g] = 0; yld[g] = 1'b0; ptr[g] = 0;
      hold_prev[g] = 1'b0; xfer_prev[g] = 1'b0; hold_dat[g] = '0;
      for (int p = 0; p < NP; p++) begin pend[g][p] = 1'b0; pval[g][p] = '0; end
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle state after reset, token transparent both ways
    head_tok = 1'b1;
    #2;
    chk(ack[0] == '0, "R1 no ack", ack[0], 0);
    chk(vld[0] == 1'b0, "R1 bus idle", vld[0], 0);
    chk(tok[NG] == 1'b1, "R1 token passes high", tok[NG], 1);
    head_tok = 1'b0;
    #1;
    chk(tok[1] == 1'b0, "R1 token passes low", tok[1], 0);
    // R1/R3: a single request at each pixel walks from pixel 0
    for (int p = NP - 1; p >= 0; p--) begin
      pend[0][p] = 1'b1;
      pval[0][p] = {2'd0, 3'(p), 23'(seq)};
      seq++;
    end
    // heavy load with stalls
    for (int c = 0; c < 3000; c++) step(50, 60, 90);
    // light load, fast bus
    for (int c = 0; c < 3000; c++) step(8, 90, 95);
    // near-saturated, mostly stalled bus
    for (int c = 0; c < 1500; c++) step(90, 25, 100);
    // drain
    for (int c = 0; c < 2000 && !all_done(); c++) step(0, 100, 100);
    chk(all_done(), "R4 no loss after drain", 0, 1);
    for (int g = 0; g < NG; g++)
      chk(q[g].size() == 0, "R4 every hit delivered once", q[g].size(), 0);
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule